// File: doc/BRIEF.md
# Banked colour RAM controller

This block stands in for a 4-bit-wide colour memory that sits on a bus shared by a CPU and a video chip, which take turns on alternate phases of the bus clock. The phase input labels every access as a CPU access or a video access. Storage is split into pages. The CPU reaches a window of four consecutive pages, starting at a CPU page register. Video fetches read one page, chosen by a separate video page register. Software can therefore build the next frame in a shadow page while the current frame is still being displayed.

A per-line mode moves the displayed page forward by one on every raster-line strobe. The step runs through a set of eight pages, counted from the video page register. A frame-start strobe sends the sequence back to that base page. The highest 24 locations of the CPU window normally hold colour data. After a four-write unlock sequence they turn into control registers, and they stay that way until software clears the mode or the block is reset. Only the low nybble is stored. The upper nybble of the data bus is never driven.

Top module: `colram_bank_ctrl`

## Requirements
- R1: After reset, register mode is off, the CPU page and the video page are both 0, per-line mode is off, the line index is 0 and rdata_o is 0. Memory contents are not cleared.
- R2: With cs_i high and phi_i high the access is a CPU access. It reaches page (cpu_page + addr_i[top two bits]) mod NUM_PAGES at offset addr_i[PAGE_AW-1:0]. A write stores wdata_i[3:0]. Read data appears on rdata_o[3:0] after the clock edge that takes the access.
- R3: With cs_i high and phi_i low the access is a video read. It reads the current video page at offset addr_i[PAGE_AW-1:0], and the upper window bits are ignored. A write in this phase changes no stored location.
- R4: rdata_oe_o is always 8'h0F and rdata_o[7:4] is always 0.
- R5: While register mode is off, the top 24 window locations (addresses WIN_SIZE-24 to WIN_SIZE-1) store data like any other location.
- R6: Register mode turns on after four back-to-back CPU accesses that are all writes to address WIN_SIZE-1 with low nybbles 0xA, 0x5, 0xC, 0x3 in that order. Any other CPU access restarts the matcher, except that a write of 0xA to that address restarts it at step two. Video accesses and idle cycles do not count. The fourth write is still stored as data.
- R7: In register mode, CPU accesses to the top 24 locations reach registers. Slot 0 (address WIN_SIZE-24) is the 4-bit CPU page. Slot 1 is the 4-bit video page. Slot 2 is control: bit 0 enables per-line mode and bit 1 is a write-only register-mode disable that reads as 0. The other slots read 0 and ignore writes. Video reads never return register contents. A page value uses its low log2(NUM_PAGES) bits.
- R8: Register mode stays on until a control write with bit 1 set, or until reset.
- R9: With per-line mode on, the video page is (video page + line index) mod NUM_PAGES. line_i advances the index modulo 8. frame_i clears the index to 0 and wins when both strobes arrive in the same cycle.
- R10: With per-line mode off, the video page equals the video page register whatever strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bus access per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phi_i | input | 1 | Bus phase: 1 = CPU, 0 = video |
| cs_i | input | 1 | Access strobe for this cycle |
| we_i | input | 1 | Write enable |
| addr_i | input | PAGE_AW+2 | Window address |
| wdata_i | input | 8 | Write data bus (low nybble stored) |
| line_i | input | 1 | Raster-line strobe |
| frame_i | input | 1 | Frame-start strobe |
| rdata_o | output | 8 | Read data, registered |
| rdata_oe_o | output | 8 | Per-bit output enable of the data bus |

## Verification
The bench uses the default build: 256-nybble pages, eight pages, a four-page window and 24 register slots. At that size every location of every page can be written through the CPU window and read back, both from the CPU side and through the video page register. The window wrap past the last page, the register shadowing of the top window locations and the full eight-step per-line cycle therefore all fall inside one short run. The model's expected contents come from an arithmetic pattern of page and offset.

// File: rtl/colram_pkg.sv
package colram_pkg;

  typedef enum logic [1:0] {
    KN_S0,
    KN_S1,
    KN_S2,
    KN_S3
  } knock_st_e;

  localparam int unsigned SLOT_CPU_PAGE = 0;
  localparam int unsigned SLOT_VID_PAGE = 1;
  localparam int unsigned SLOT_CTRL     = 2;

  localparam int unsigned CTRL_PER_LINE = 0;
  localparam int unsigned CTRL_REG_OFF  = 1;

  function automatic logic [3:0] knock_nib(knock_st_e st);
    case (st)
      KN_S0:   return 4'hA;
      KN_S1:   return 4'h5;
      KN_S2:   return 4'hC;
      default: return 4'h3;
    endcase
  endfunction

endpackage

// File: rtl/colram_knock.sv
module colram_knock
  import colram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_acc_i,
  input  logic       we_i,
  input  logic       top_hit_i,
  input  logic [3:0] wnib_i,
  input  logic       disable_i,
  output logic       reg_mode_o
);

  knock_st_e st_q;
  logic      reg_mode_q;
  logic      step_ok, restart_ok;

  assign step_ok    = cpu_acc_i && we_i && top_hit_i && (wnib_i == knock_nib(st_q));
  assign restart_ok = cpu_acc_i && we_i && top_hit_i && (wnib_i == knock_nib(KN_S0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= KN_S0;
      reg_mode_q <= 1'b0;
    end else begin
      if (cpu_acc_i) begin
        if (step_ok) begin
          if (st_q == KN_S3) begin
            st_q       <= KN_S0;
            reg_mode_q <= 1'b1;
          end else begin
            st_q <= knock_st_e'(st_q + 2'd1);
          end
        end else if (restart_ok) begin
          st_q <= KN_S1;
        end else begin
          st_q <= KN_S0;
        end
      end
      if (disable_i) reg_mode_q <= 1'b0;
    end
  end

  assign reg_mode_o = reg_mode_q;

  // R6
  knock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_mode_q) |-> $past(cpu_acc_i && we_i && top_hit_i && wnib_i == 4'h3));

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_mode_q) |-> $past(disable_i));

endmodule

// File: rtl/colram_regs.sv
module colram_regs
  import colram_pkg::*;
#(
  parameter int unsigned PG_W  = 3,
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [3:0]       wnib_i,
  output logic [3:0]       rnib_o,
  output logic [PG_W-1:0]  cpu_page_o,
  output logic [PG_W-1:0]  vid_base_o,
  output logic             per_line_o,
  output logic             disable_o
);

  logic [3:0] cpu_page_q, vid_page_q;
  logic       per_line_q;
  logic       hit_cpu, hit_vid, hit_ctrl;

  assign hit_cpu  = sel_i == SEL_W'(SLOT_CPU_PAGE);
  assign hit_vid  = sel_i == SEL_W'(SLOT_VID_PAGE);
  assign hit_ctrl = sel_i == SEL_W'(SLOT_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_page_q <= '0;
      vid_page_q <= '0;
      per_line_q <= 1'b0;
    end else if (wr_i) begin
      if (hit_cpu)  cpu_page_q <= wnib_i;
      if (hit_vid)  vid_page_q <= wnib_i;
      if (hit_ctrl) per_line_q <= wnib_i[CTRL_PER_LINE];
    end
  end

  always_comb begin
    rnib_o = '0;
    if (hit_cpu)       rnib_o = cpu_page_q;
    else if (hit_vid)  rnib_o = vid_page_q;
    else if (hit_ctrl) rnib_o = {3'b000, per_line_q};
  end

  assign cpu_page_o = cpu_page_q[PG_W-1:0];
  assign vid_base_o = vid_page_q[PG_W-1:0];
  assign per_line_o = per_line_q;
  assign disable_o  = wr_i && hit_ctrl && wnib_i[CTRL_REG_OFF];

  // R7
  cpu_page_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && hit_cpu) |=> $stable(cpu_page_q));

endmodule

// File: rtl/colram_vidseq.sv
module colram_vidseq #(
  parameter int unsigned PG_W       = 3,
  parameter int unsigned LINE_PAGES = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_i,
  input  logic            frame_i,
  input  logic            per_line_i,
  input  logic [PG_W-1:0] base_i,
  output logic [PG_W-1:0] vid_page_o
);

  localparam int unsigned LS_W = (LINE_PAGES > 1) ? $clog2(LINE_PAGES) : 1;
  localparam logic [LS_W-1:0] IDX_LAST = LS_W'(LINE_PAGES - 1);

  logic [LS_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (frame_i)   idx_q <= '0;
    else if (line_i)    idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + LS_W'(1);
  end

  assign vid_page_o = per_line_i ? base_i + PG_W'(idx_q) : base_i;

  // R9
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> idx_q == '0);

  // R9
  line_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !frame_i) |=>
      idx_q == (($past(idx_q) == IDX_LAST) ? '0 : $past(idx_q) + LS_W'(1)));

endmodule

// File: rtl/colram_store.sv
module colram_store #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    wnib_i,
  output logic [3:0]    rnib_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [3:0] mem_q [DEPTH];
  logic [3:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem_q[addr_i] <= wnib_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rd_q <= '0;
    else if (en_i && !we_i)   rd_q <= mem_q[addr_i];
  end

  assign rnib_o = rd_q;

endmodule

// File: rtl/colram_bank_ctrl.sv
module colram_bank_ctrl #(
  parameter int unsigned PAGE_AW    = 8,
  parameter int unsigned NUM_PAGES  = 8,
  parameter int unsigned WIN_PAGES  = 4,
  parameter int unsigned REG_SLOTS  = 24,
  parameter int unsigned LINE_PAGES = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 phi_i,
  input  logic                                 cs_i,
  input  logic                                 we_i,
  input  logic [PAGE_AW+$clog2(WIN_PAGES)-1:0] addr_i,
  input  logic [7:0]                           wdata_i,
  input  logic                                 line_i,
  input  logic                                 frame_i,
  output logic [7:0]                           rdata_o,
  output logic [7:0]                           rdata_oe_o
);

  localparam int unsigned WS_W     = $clog2(WIN_PAGES);
  localparam int unsigned WIN_AW   = PAGE_AW + WS_W;
  localparam int unsigned WIN_SIZE = 1 << WIN_AW;
  localparam int unsigned PG_W     = $clog2(NUM_PAGES);
  localparam int unsigned MEM_AW   = PG_W + PAGE_AW;
  localparam int unsigned SEL_W    = $clog2(REG_SLOTS);
  localparam logic [WIN_AW-1:0] REG_BASE = WIN_AW'(WIN_SIZE - REG_SLOTS);
  localparam logic [WIN_AW-1:0] TOP_ADDR = WIN_AW'(WIN_SIZE - 1);

  logic              cpu_acc, vid_acc, reg_mode, reg_acc, in_reg_win, top_hit;
  logic              mem_en, mem_we;
  logic [PG_W-1:0]   cpu_page, vid_base, vid_page, phys_page;
  logic [MEM_AW-1:0] mem_addr;
  logic [SEL_W-1:0]  reg_sel;
  logic [3:0]        reg_rnib, mem_rnib, reg_q;
  logic              per_line, reg_off, src_reg_q;
  logic              unused_hi;

  assign unused_hi = ^wdata_i[7:4];

  assign cpu_acc    = cs_i && phi_i;
  assign vid_acc    = cs_i && !phi_i;
  assign in_reg_win = addr_i >= REG_BASE;
  assign top_hit    = addr_i == TOP_ADDR;
  assign reg_acc    = cpu_acc && reg_mode && in_reg_win;
  assign reg_sel    = SEL_W'(addr_i - REG_BASE);

  // CPU side offsets its page by the window slot, video side reads one page
  assign phys_page = phi_i ? cpu_page + PG_W'(addr_i[WIN_AW-1:PAGE_AW]) : vid_page;
  assign mem_addr  = {phys_page, addr_i[PAGE_AW-1:0]};
  assign mem_en    = (cpu_acc && !reg_acc) || (vid_acc && !we_i);
  assign mem_we    = cpu_acc && !reg_acc && we_i;

  colram_knock u_knock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_acc_i  (cpu_acc),
    .we_i       (we_i),
    .top_hit_i  (top_hit),
    .wnib_i     (wdata_i[3:0]),
    .disable_i  (reg_off),
    .reg_mode_o (reg_mode)
  );

  colram_regs #(
    .PG_W  (PG_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_acc && we_i),
    .sel_i      (reg_sel),
    .wnib_i     (wdata_i[3:0]),
    .rnib_o     (reg_rnib),
    .cpu_page_o (cpu_page),
    .vid_base_o (vid_base),
    .per_line_o (per_line),
    .disable_o  (reg_off)
  );

  colram_vidseq #(
    .PG_W       (PG_W),
    .LINE_PAGES (LINE_PAGES)
  ) u_vidseq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .frame_i    (frame_i),
    .per_line_i (per_line),
    .base_i     (vid_base),
    .vid_page_o (vid_page)
  );

  colram_store #(
    .AW (MEM_AW)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mem_en),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wnib_i (wdata_i[3:0]),
    .rnib_o (mem_rnib)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_reg_q <= 1'b0;
      reg_q     <= '0;
    end else if (reg_acc && !we_i) begin
      src_reg_q <= 1'b1;
      reg_q     <= reg_rnib;
    end else if (mem_en && !mem_we) begin
      src_reg_q <= 1'b0;
    end
  end

  assign rdata_o    = {4'h0, src_reg_q ? reg_q : mem_rnib};
  assign rdata_oe_o = 8'h0F;

  // R7
  vid_no_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_acc && !we_i) |=> !src_reg_q);

  // R3
  vid_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_acc |-> !mem_we);

endmodule

// File: tb/colram_bank_ctrl_tb.sv
module colram_bank_ctrl_tb_top;

  localparam int PAW  = 8;
  localparam int NP   = 8;
  localparam int PSZ  = 1 << PAW;
  localparam int WIN  = 4 * PSZ;
  localparam int RB   = WIN - 24;
  localparam int TOPA = WIN - 1;

  logic       clk = 1'b0;
  logic       rst_n, phi, cs, we, line, frame;
  logic [9:0] addr;
  logic [7:0] wd;
  wire  [7:0] rd, oe;

  always #4 clk = ~clk;

  colram_bank_ctrl dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .phi_i      (phi),
    .cs_i       (cs),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wd),
    .line_i     (line),
    .frame_i    (frame),
    .rdata_o    (rd),
    .rdata_oe_o (oe)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int mdl   [NP*PSZ];
  bit known [NP*PSZ];
  int e_reg, e_cpu, e_vid, e_pl, e_idx;

  function automatic int pat(int idx);
    return (idx * 3 + (idx >> 4) + (idx >> 8) * 5) & 15;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic bus(bit p, bit w, int a, int d);
    phi = p; cs = 1'b1; we = w; addr = 10'(a); wd = 8'(d);
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  function automatic int cpu_idx(int a);
    return (((e_cpu & 7) + (a >> PAW)) & 7) * PSZ + (a & (PSZ - 1));
  endfunction

  function automatic int vid_page();
    return e_pl ? (((e_vid & 7) + e_idx) & 7) : (e_vid & 7);
  endfunction

  task automatic cpu_wr(int a, int d);
    bus(1, 1, a, d);
    if (e_reg && a >= RB) begin
      case (a - RB)
        0: e_cpu = d & 15;
        1: e_vid = d & 15;
        2: begin e_pl = d & 1; if (d & 2) e_reg = 0; end
        default: ;
      endcase
    end else begin
      mdl[cpu_idx(a)]   = d & 15;
      known[cpu_idx(a)] = 1'b1;
    end
  endtask

  task automatic cpu_rd(int a, string tag);
    int exp;
    bit ok;
    bus(1, 0, a, 0);
    ok = 1'b1;
    if (e_reg && a >= RB) begin
      case (a - RB)
        0: exp = e_cpu;
        1: exp = e_vid;
        2: exp = e_pl;
        default: exp = 0;
      endcase
    end else begin
      ok  = known[cpu_idx(a)];
      exp = mdl[cpu_idx(a)];
    end
    if (ok) chk(tag, int'(rd[3:0]), exp);
    chk("R4 upper nybble", int'({oe, rd[7:4]}), 12'h0F0);
  endtask

  task automatic vid_rd(int a, string tag);
    int i;
    bus(0, 0, a, 0);
    i = vid_page() * PSZ + (a & (PSZ - 1));
    if (known[i]) chk(tag, int'(rd[3:0]), mdl[i]);
    chk("R4 upper nybble", int'({oe, rd[7:4]}), 12'h0F0);
  endtask

  task automatic pulse(bit l, bit f);
    line = l; frame = f;
    @(negedge clk);
    line = 1'b0; frame = 1'b0;
    if (f) e_idx = 0;
    else if (l) e_idx = (e_idx + 1) % 8;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e_reg = 0; e_cpu = 0; e_vid = 0; e_pl = 0; e_idx = 0;
  endtask

  task automatic knock_ok();
    cpu_wr(TOPA, 4'hA);
    vid_rd(3, "R6 interleaved video");
    cpu_wr(TOPA, 4'h5);
    @(negedge clk);
    cpu_wr(TOPA, 4'hC);
    cpu_wr(TOPA, 4'h3);
    e_reg = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phi = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wd = '0;
    line = 1'b0; frame = 1'b0;
    for (int i = 0; i < NP * PSZ; i++) begin mdl[i] = 0; known[i] = 1'b0; end
    @(negedge clk);
    do_reset();
    // R1
    chk("R1 rdata after reset", int'(rd), 0);
    chk("R4 oe after reset", int'(oe), 8'h0F);

    // R2: fill pages 0..3 through the window and read back
    for (int a = 0; a < WIN; a++) cpu_wr(a, pat(cpu_idx(a)));
    for (int a = 0; a < WIN; a++) cpu_rd(a, "R2 cpu window page0");
    // R3: video page 0, upper address bits ignored
    for (int o = 0; o < PSZ; o++) vid_rd(o | ((o & 3) << PAW), "R3 video page0");

    // R5: top locations are storage before unlock
    cpu_wr(RB, 9);
    cpu_rd(RB, "R5 top slot storage");
    cpu_wr(TOPA - 1, 4);
    cpu_rd(TOPA - 1, "R5 top slot storage");

    // R6: broken knock leaves storage mode
    cpu_wr(TOPA, 4'hA);
    cpu_wr(TOPA, 4'h5);
    cpu_rd(0, "R2 cpu read");
    cpu_wr(TOPA, 4'hC);
    cpu_wr(TOPA, 4'h3);
    cpu_wr(RB, 6);
    cpu_rd(RB, "R6 no unlock after broken knock");
    cpu_rd(TOPA, "R6 last knock write stored");

    // R6: valid knock with a repeated first step, video and idle in between
    cpu_wr(TOPA, 4'hA);
    knock_ok();
    cpu_rd(RB, "R7 cpu page reg after unlock");
    chk("R7 reg slot differs from stored 6", int'(rd[3:0]), 0);
    cpu_rd(TOPA, "R6 stored fourth knock write hidden by regs");

    // R7: register map
    cpu_wr(RB, 4);
    cpu_rd(RB, "R7 cpu page readback");
    cpu_wr(RB + 5, 15);
    cpu_rd(RB + 5, "R7 unused slot reads zero");
    cpu_wr(RB + 2, 4'hD);
    cpu_rd(RB + 2, "R7 ctrl reads per-line only");
    cpu_wr(RB + 2, 0);

    // R2: fill pages 4..7
    for (int a = 0; a < RB; a++) cpu_wr(a, pat(cpu_idx(a)));
    for (int a = 0; a < RB; a++) cpu_rd(a, "R2 cpu window page4");
    // R2: window wraps past last page
    cpu_wr(RB, 6);
    for (int a = 0; a < RB; a++) cpu_rd(a, "R2 cpu window wrap");

    // R3: every page from the video side while cpu page stays 6
    for (int p = 0; p < NP; p++) begin
      cpu_wr(RB + 1, p);
      for (int o = 0; o < PSZ; o++) vid_rd(o, "R3 video page sweep");
    end

    // R3: video write ignored
    vid_rd(10, "R3 before video write");
    bus(0, 1, 10, ~mdl[7 * PSZ + 10]);
    vid_rd(10, "R3 video write ignored");

    // R9: per-line stepping from base 2
    cpu_wr(RB + 1, 2);
    cpu_wr(RB + 2, 1);
    pulse(0, 1);
    for (int k = 0; k < 12; k++) begin
      vid_rd(17, "R9 per-line page");
      chk("R9 line index page", vid_page(), (2 + k) & 7);
      pulse(1, 0);
    end
    pulse(0, 1);
    vid_rd(17, "R9 frame restart");
    pulse(1, 0);
    pulse(1, 1);
    vid_rd(18, "R9 frame wins over line");

    // R10: per-line off ignores strobes
    cpu_wr(RB + 2, 0);
    pulse(1, 0);
    pulse(1, 0);
    vid_rd(19, "R10 static video page");
    pulse(1, 0);
    vid_rd(20, "R10 static video page");

    // R8: mode holds until disable
    cpu_rd(RB + 1, "R8 still in register mode");
    cpu_wr(RB + 2, 2);
    cpu_wr(RB, 4'hB);
    cpu_rd(RB, "R8 storage after disable");

    // R1: reset mid-run clears mode and pages
    knock_ok();
    cpu_wr(RB, 5);
    cpu_wr(RB + 2, 1);
    do_reset();
    cpu_rd(RB, "R1 storage after reset");
    cpu_rd(1, "R1 cpu page 0 after reset");
    vid_rd(5, "R1 video page 0 after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule